// File: doc/BRIEF.md
# Ring-Oscillator Temperature Measurement Counter

This block measures the frequency of an on-chip, temperature-dependent ring oscillator. The bus clock is slowed by a programmable divider, and the resulting reference ticks are counted across a window of 1 to 15 oscillator periods. Each finished count is stored in a result register. Because the count is inversely proportional to the oscillator frequency, software derives temperature from the reference frequency times the window length divided by the count. Read-only calibration constants are available for that conversion.

A measurement runs in one of two ways. In free-running mode, conversions follow one another with no gap. In trigger mode, one of four trigger lines is selected, and a single conversion starts on each rising edge of that line. Every result is compared against a low limit and a high limit. The end-of-measurement event and each limit event set two sticky status flags: a primary copy and a wake copy. Every flag has its own enable bit. Flags are cleared by writing ones to a clear register. The single interrupt line is raised while any enabled flag is set.

Top module: `tsense_meas_top`

## Requirements
- R1: After reset, the following all read zero: control (address 0), result (address 3), status (address 5), enables (address 6) and `irq`. The limits word (address 4) reads 0x0000FFFF.
- R2: Two addresses return the calibration constants. Address 1 holds the frequency code in bits [15:0] and the calibration-temperature code in bit 16. Address 2 holds the ramp coefficient in bits [15:0].
- R3: A result equals the number of reference ticks counted between two synchronized oscillator rising edges that lie `smp` periods apart. `smp` is control bits [11:8], and the value 0 acts as 1. With a divide value of 1, the result equals the oscillator period in clock cycles times `smp`.
- R4: Trigger code 0 (control bits [6:4]) runs free. After the enable bit (control bit 0) and the run bit (control bit 1) are both set, results keep arriving without any further action.
- R5: The divide field (control bits [22:16], with 0 acting as 1) produces one reference tick every `div` clock cycles. A window of L cycles therefore counts L/div when L is a multiple of `div`.
- R6: Trigger codes 1 to 4 select `trig_in[code-1]`. Each rising edge on the selected line gives exactly one measurement. Edges on the other lines, and the absence of any edge, produce no result.
- R7: A rising edge on the selected trigger line that arrives while a measurement is in progress is ignored.
- R8: Clearing the enable bit stops any measurement in progress, and no result is produced afterwards.
- R9: The low flag (status bit 1) is set when a result is greater than the low limit (address 4 bits [15:0]). The high flag (status bit 2) is set when a result is less than the high limit (address 4 bits [31:16]).
- R10: Writing a one to a bit of address 7 clears the matching status bit. Writing zeros has no effect.
- R11: `irq` is high exactly when some status bit and the enable bit at the same position (address 6) are both one.
- R12: Each event sets its primary status bit (bits [2:0]: done, low, high) and its wake copy (bits [5:3], in the same order). The two copies are enabled and cleared separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| osc_in | input | 1 | Sensor oscillator, asynchronous |
| trig_in | input | 4 | External trigger lines, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a second trigger edge landing inside a measurement that is already running. There is no busy bit at the ports, so the stimulus cannot wait for the block to become busy. Instead, the bench fires the second pulse a few cycles after the first, which is well inside the alignment delay plus a 16-cycle window. It then shows that exactly one result appears and that the done flag stays clear for a long time afterwards. Disabling the block mid-measurement is reached the same way: a 150-cycle window is started, and the enable bit is dropped part way through.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int DIV_W  = 7;
    localparam int SMP_W  = 4;
    localparam int TSEL_W = 3;
    localparam int NFLAG  = 6;
    localparam int NEVT   = 3;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_CAL_F  = 3'd1;
    localparam logic [2:0] A_CAL_R  = 3'd2;
    localparam logic [2:0] A_RESULT = 3'd3;
    localparam logic [2:0] A_LIMITS = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;
    localparam logic [2:0] A_IEN    = 3'd6;
    localparam logic [2:0] A_CLR    = 3'd7;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_ALIGN = 2'd1,
        M_COUNT = 2'd2
    } meas_state_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SMP_W-1:0]  smp;
        logic [TSEL_W-1:0] trig;
        logic              start;
        logic              en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.en    = w[0];
        c.start = w[1];
        c.trig  = w[6:4];
        c.smp   = w[11:8];
        c.div   = w[22:16];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.en;
        w[1]     = c.start;
        w[6:4]   = c.trig;
        w[11:8]  = c.smp;
        w[22:16] = c.div;
        return w;
    endfunction

    function automatic logic [SMP_W-1:0] smp_eff(input logic [SMP_W-1:0] s);
        return (s == '0) ? SMP_W'(1) : s;
    endfunction

endpackage

// File: rtl/tsm_sync_edge.sv
module tsm_sync_edge #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-1:0], d[g]};
        end
        assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/tsm_refdiv.sv
module tsm_refdiv #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] q;
    logic [DW-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - DW'(1);
    assign tick = (q >= lim);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (tick) q <= '0;
        else           q <= q + DW'(1);
    end
endmodule

// File: rtl/tsm_meas_core.sv
module tsm_meas_core
    import tsm_pkg::*;
#(
    parameter int CW    = 16,
    parameter int NTRIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [TSEL_W-1:0] trig,
    input  logic [SMP_W-1:0]  smp,
    input  logic [NTRIG-1:0]  trig_rise,
    input  logic              osc_rise,
    input  logic              tick,
    output logic              busy,
    output logic              done,
    output logic [CW-1:0]     count
);
    meas_state_e      state;
    logic [CW-1:0]    cnt;
    logic [SMP_W-1:0] edges;
    logic             sel_edge;
    logic             sw_mode;
    logic             last_edge;

    assign sw_mode = (trig == '0);

    always_comb begin
        sel_edge = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (trig == TSEL_W'(i + 1)) sel_edge = trig_rise[i];
        end
    end

    assign count     = (tick && (cnt != '1)) ? cnt + CW'(1) : cnt;
    assign last_edge = ({1'b0, edges} + (SMP_W+1)'(1)) == {1'b0, smp_eff(smp)};
    assign done      = (state == M_COUNT) && run && osc_rise && last_edge;
    assign busy      = (state != M_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= M_IDLE;
            cnt   <= '0;
            edges <= '0;
        end else begin
            case (state)
                M_IDLE: begin
                    if (run && (sw_mode || sel_edge)) state <= M_ALIGN;
                end
                M_ALIGN: begin
                    if (!run) begin
                        state <= M_IDLE;
                    end else if (osc_rise) begin
                        state <= M_COUNT;
                        cnt   <= '0;
                        edges <= '0;
                    end
                end
                M_COUNT: begin
                    if (!run) begin
                        state <= M_IDLE;
                    end else if (osc_rise) begin
                        if (last_edge) begin
                            cnt   <= '0;
                            edges <= '0;
                            if (!sw_mode) state <= M_IDLE;
                        end else begin
                            edges <= edges + SMP_W'(1);
                            cnt   <= count;
                        end
                    end else begin
                        cnt <= count;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tsm_regs.sv
module tsm_regs
    import tsm_pkg::*;
#(
    parameter int          CW        = 16,
    parameter logic        CAL_TCODE = 1'b0,
    parameter logic [15:0] CAL_FREQ  = 16'd6100,
    parameter logic [15:0] CAL_RAMP  = 16'd120
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             meas_done,
    input  logic [CW-1:0]    meas_count,
    output ctrl_t            ctrl,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] ien,
    output logic [CW-1:0]    lim_lo,
    output logic [CW-1:0]    lim_hi,
    output logic [CW-1:0]    result,
    output logic             clr_we,
    output logic             irq
);
    logic            wr;
    logic [NEVT-1:0] evt;

    assign wr     = bus_en && bus_we;
    assign clr_we = wr && (bus_addr == A_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            ien    <= '0;
            lim_lo <= '1;
            lim_hi <= '0;
            result <= '0;
        end else begin
            if (wr && bus_addr == A_CTRL) ctrl <= ctrl_unpack(bus_wdata);
            if (wr && bus_addr == A_IEN)  ien  <= bus_wdata[NFLAG-1:0];
            if (wr && bus_addr == A_LIMITS) begin
                lim_lo <= bus_wdata[CW-1:0];
                lim_hi <= bus_wdata[16 +: CW];
            end
            if (meas_done) result <= meas_count;
        end
    end

    assign evt[0] = meas_done;
    assign evt[1] = meas_done && (meas_count > lim_lo);
    assign evt[2] = meas_done && (meas_count < lim_hi);

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                        flags[g] <= 1'b0;
            else if (evt[g % NEVT])         flags[g] <= 1'b1;
            else if (clr_we && bus_wdata[g]) flags[g] <= 1'b0;
        end
    end

    assign irq = |(flags & ien);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_pack(ctrl);
            A_CAL_F:  bus_rdata = {15'd0, CAL_TCODE, CAL_FREQ};
            A_CAL_R:  bus_rdata = {16'd0, CAL_RAMP};
            A_RESULT: bus_rdata[CW-1:0] = result;
            A_LIMITS: begin
                bus_rdata[CW-1:0]  = lim_lo;
                bus_rdata[16 +: CW] = lim_hi;
            end
            A_STATUS: bus_rdata[NFLAG-1:0] = flags;
            A_IEN:    bus_rdata[NFLAG-1:0] = ien;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsense_meas_top.sv
module tsense_meas_top
    import tsm_pkg::*;
#(
    parameter int          NTRIG     = 4,
    parameter logic        CAL_TCODE = 1'b0,
    parameter logic [15:0] CAL_FREQ  = 16'd6100,
    parameter logic [15:0] CAL_RAMP  = 16'd120
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             osc_in,
    input  logic [NTRIG-1:0] trig_in,
    output logic             irq
);
    localparam int CW = 16;

    ctrl_t            ctrl_q;
    logic             run_en;
    logic             osc_rise;
    logic [NTRIG-1:0] trig_rise;
    logic             ref_tick;
    logic             meas_busy;
    logic             meas_done;
    logic [CW-1:0]    meas_count;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] ien_q;
    logic [CW-1:0]    lim_lo;
    logic [CW-1:0]    lim_hi;
    logic [CW-1:0]    result_q;
    logic             clr_we;

    assign run_en = ctrl_q.en && ctrl_q.start;

    tsm_sync_edge #(.W(1), .STAGES(2)) u_osc_sync (
        .clk(clk), .rst(rst), .d(osc_in), .rise(osc_rise)
    );

    tsm_sync_edge #(.W(NTRIG), .STAGES(2)) u_trig_sync (
        .clk(clk), .rst(rst), .d(trig_in), .rise(trig_rise)
    );

    tsm_refdiv #(.DW(DIV_W)) u_refdiv (
        .clk(clk), .rst(rst), .div(ctrl_q.div), .tick(ref_tick)
    );

    tsm_meas_core #(.CW(CW), .NTRIG(NTRIG)) u_core (
        .clk(clk), .rst(rst), .run(run_en), .trig(ctrl_q.trig),
        .smp(ctrl_q.smp), .trig_rise(trig_rise), .osc_rise(osc_rise),
        .tick(ref_tick), .busy(meas_busy), .done(meas_done),
        .count(meas_count)
    );

    tsm_regs #(
        .CW(CW), .CAL_TCODE(CAL_TCODE), .CAL_FREQ(CAL_FREQ), .CAL_RAMP(CAL_RAMP)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .meas_done(meas_done), .meas_count(meas_count), .ctrl(ctrl_q),
        .flags(flags_q), .ien(ien_q), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .result(result_q), .clr_we(clr_we), .irq(irq)
    );
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        busy,
    input logic        done,
    input logic [15:0] count,
    input logic        osc_rise,
    input logic [15:0] result,
    input logic [5:0]  flags,
    input logic [5:0]  ien,
    input logic        irq,
    input logic [15:0] lim_lo,
    input logic [15:0] lim_hi,
    input logic        clr_we,
    input logic [31:0] clr_data
);
    // R8: dropping the enable returns the core to idle
    p_stop_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !busy);

    // R3: the result register only moves after a completed window
    p_result_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        (result != $past(result)) |-> $past(done));

    // R3: a window closes only on an oscillator edge
    p_done_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> osc_rise);

    // R9: limit comparisons set their flags and wake copies
    p_low_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (done && count > lim_lo) |=> (flags[1] && flags[4]));
    p_high_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (done && count < lim_hi) |=> (flags[2] && flags[5]));

    // R10: a one written to the clear register drops the done flag
    p_clear_done_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_data[0] && !done) |=> !flags[0]);

    // R11: interrupt rises only with an enabled flag present
    p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((flags & ien) != 6'd0));
endmodule

bind tsense_meas_top tsm_checker u_chk (
    .clk(clk), .rst(rst), .run(run_en), .busy(meas_busy), .done(meas_done),
    .count(meas_count), .osc_rise(osc_rise), .result(result_q),
    .flags(flags_q), .ien(ien_q), .irq(irq), .lim_lo(lim_lo),
    .lim_hi(lim_hi), .clr_we(clr_we), .clr_data(bus_wdata)
);

// File: tb/tsense_meas_top_tb.sv
module tsense_meas_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        osc_in;
    logic [3:0]  trig_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int osc_p = 0;
    bit finished = 0;
    int unsigned exp_q[$];

    always #2.5 clk = ~clk;

    tsense_meas_top #(
        .NTRIG(4), .CAL_TCODE(1'b1), .CAL_FREQ(16'h1A2B), .CAL_RAMP(16'h0F0E)
    ) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_in(osc_in), .trig_in(trig_in), .irq(irq)
    );

    initial begin
        osc_in = 1'b0;
        forever begin
            if (osc_p < 2) begin
                @(negedge clk);
                osc_in = 1'b0;
            end else begin
                osc_in = 1'b1;
                repeat (osc_p / 2) @(negedge clk);
                osc_in = 1'b0;
                repeat (osc_p - osc_p / 2) @(negedge clk);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit en, input bit st, input int tr,
                                            input int smp, input int dv);
        return (32'(dv) << 16) | (32'(smp) << 8) | (32'(tr) << 4) | (32'(st) << 1) | 32'(en);
    endfunction

    // driver side: record the value the next result must carry
    task automatic expect_result(input int unsigned v);
        exp_q.push_back(v);
    endtask

    // monitor side: wait for an end-of-measurement interrupt, compare, clear
    task automatic mon_take(input string req);
        int waited;
        logic [31:0] r;
        int unsigned e;
        waited = 0;
        while (!irq && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
        if (!irq) begin
            chk({req, " no result"}, 32'd0, 32'd1);
        end else begin
            bus_read(3'd3, r);
            chk(req, r, 32'(e));
            bus_write(3'd7, 32'h09);
        end
    endtask

    task automatic stop_and_clear();
        bus_write(3'd0, 32'd0);
        bus_write(3'd7, 32'h3F);
    endtask

    task automatic pulse_trig(input int idx);
        @(negedge clk);
        trig_in[idx] = 1'b1;
        repeat (3) @(negedge clk);
        trig_in[idx] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd0, r); chk("R1 ctrl", r, 0);
        bus_read(3'd3, r); chk("R1 result", r, 0);
        bus_read(3'd5, r); chk("R1 status", r, 0);
        bus_read(3'd6, r); chk("R1 ien", r, 0);
        bus_read(3'd4, r); chk("R1 limits", r, 32'h0000FFFF);
        chk("R1 irq", 32'(irq), 0);

        // R2 calibration constants
        bus_read(3'd1, r); chk("R2 cal freq/tcode", r, 32'h00011A2B);
        bus_read(3'd2, r); chk("R2 cal ramp", r, 32'h00000F0E);

        // R4 / R3 continuous mode, period 8, window 3
        bus_write(3'd6, 32'h09);
        osc_p = 8;
        expect_result(24); expect_result(24); expect_result(24);
        bus_write(3'd0, mk_ctrl(1, 1, 0, 3, 1));
        bus_read(3'd0, r); chk("R4 ctrl readback", r, mk_ctrl(1, 1, 0, 3, 1));
        mon_take("R4 first result");
        mon_take("R4 second result");
        mon_take("R4 third result");
        stop_and_clear();

        // R3 longest window and single period
        osc_p = 4; expect_result(60);
        bus_write(3'd0, mk_ctrl(1, 1, 0, 15, 1));
        mon_take("R3 window 15");
        stop_and_clear();
        osc_p = 10; expect_result(10);
        bus_write(3'd0, mk_ctrl(1, 1, 0, 1, 1));
        mon_take("R3 window 1");
        stop_and_clear();
        osc_p = 12; expect_result(12);
        bus_write(3'd0, mk_ctrl(1, 1, 0, 0, 1));
        mon_take("R3 window 0 acts as 1");
        stop_and_clear();

        // R5 divider
        osc_p = 8; expect_result(8);
        bus_write(3'd0, mk_ctrl(1, 1, 0, 2, 2));
        mon_take("R5 divide by 2");
        stop_and_clear();
        expect_result(8);
        bus_write(3'd0, mk_ctrl(1, 1, 0, 4, 4));
        mon_take("R5 divide by 4");
        stop_and_clear();

        // R6 trigger mode, code 2 selects trig_in[1]
        osc_p = 8;
        bus_write(3'd0, mk_ctrl(1, 1, 2, 2, 1));
        repeat (100) @(negedge clk);
        bus_read(3'd5, r); chk("R6 no edge no result", r, 0);
        pulse_trig(0);
        repeat (100) @(negedge clk);
        bus_read(3'd5, r); chk("R6 other line ignored", r, 0);
        expect_result(16);
        pulse_trig(1);
        mon_take("R6 triggered result");
        repeat (100) @(negedge clk);
        bus_read(3'd5, r); chk("R6 single shot", r, 0);

        // R7 second edge during a measurement
        expect_result(16);
        pulse_trig(1);
        repeat (4) @(negedge clk);
        pulse_trig(1);
        mon_take("R7 first of two edges");
        repeat (120) @(negedge clk);
        bus_read(3'd5, r); chk("R7 busy edge ignored", r, 0);
        stop_and_clear();

        // R8 disable mid measurement
        osc_p = 10;
        bus_write(3'd0, mk_ctrl(1, 1, 0, 15, 1));
        repeat (40) @(negedge clk);
        bus_write(3'd0, mk_ctrl(0, 1, 0, 15, 1));
        repeat (300) @(negedge clk);
        bus_read(3'd5, r); chk("R8 no result after disable", r, 0);
        chk("R8 irq low", 32'(irq), 0);
        bus_write(3'd7, 32'h3F);

        // R9 / R12 limits: low 20, high 10
        bus_write(3'd4, {16'd10, 16'd20});
        osc_p = 8; expect_result(24);
        bus_write(3'd0, mk_ctrl(1, 1, 1, 3, 1));
        pulse_trig(0);
        mon_take("R9 result 24");
        bus_read(3'd5, r); chk("R9 R12 low flag and wake copy", r, 32'h12);
        bus_write(3'd7, 32'h3F);
        osc_p = 4; expect_result(8);
        bus_write(3'd0, mk_ctrl(1, 1, 1, 2, 1));
        pulse_trig(0);
        mon_take("R9 result 8");
        bus_read(3'd5, r); chk("R9 R12 high flag and wake copy", r, 32'h24);

        // R10 write-one clear
        bus_write(3'd7, 32'h00);
        bus_read(3'd5, r); chk("R10 zero write no effect", r, 32'h24);
        bus_write(3'd7, 32'h04);
        bus_read(3'd5, r); chk("R10 clear primary only", r, 32'h20);
        bus_write(3'd7, 32'h20);
        bus_read(3'd5, r); chk("R10 clear wake copy", r, 0);

        // R11 irq gating by enables
        bus_write(3'd6, 32'h00);
        osc_p = 8;
        bus_write(3'd0, mk_ctrl(1, 1, 1, 3, 1));
        pulse_trig(0);
        repeat (80) @(negedge clk);
        #1 chk("R11 irq low with no enables", 32'(irq), 0);
        bus_read(3'd5, r); chk("R11 R12 flags set", r, 32'h1B);
        bus_read(3'd3, r); chk("R11 result", r, 24);
        bus_write(3'd6, 32'h02);
        #1 chk("R11 irq from low enable", 32'(irq), 1);
        bus_write(3'd6, 32'h10);
        #1 chk("R12 irq from wake low enable", 32'(irq), 1);
        bus_write(3'd7, 32'h10);
        #1 chk("R11 irq drops after clear", 32'(irq), 0);
        stop_and_clear();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule